// File: doc/BRIEF.md
# Byte-Serial Memory Access Sequencer

This block connects a 32-bit processor core to a memory system whose data path is one byte wide. The core places one load or store of 1, 2 or 4 bytes on a request port. The block runs that access as a series of single-byte bus cycles, one per clock, at consecutive addresses. Multi-byte values are little-endian: the least significant byte sits at the lowest address. When the last byte is done, the block gives the core a one-cycle acknowledge, together with the assembled read data.

The block also routes each byte cycle to one of four banks, chosen from the two top address bits:
- a low RAM of 4096 bytes,
- a ROM of 4096 bytes,
- a peripheral area starting at 0x8000,
- a high RAM of 4096 bytes.

All banks share one byte address bus and one write-data bus. Each bank has its own enable strobe and its own read-data return. The banks are modelled as synchronous: a byte strobed in one cycle returns its read data in the next. Stores into the ROM bank never raise the write enable.

The controller has four states:
- IDLE waits for a request.
- XFER issues one byte cycle per clock.
- TAIL takes in the read byte of the last cycle of a load.
- ACK signals completion.

Its transitions are:
- IDLE→XFER when `req_valid` is sampled high.
- XFER→XFER while bytes remain.
- XFER→TAIL after the last byte of a load.
- XFER→ACK after the last byte of a store.
- TAIL→ACK always.
- ACK→IDLE always.

Top module: `mem_byte_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `bank_en`, `bus_we` and `req_ack` are all low.
- R2: Address bits 15:14 select the bank of each byte cycle. The selection is 00 → `bank_en[0]` (low RAM), 01 → `bank_en[1]` (ROM), 10 → `bank_en[2]` (peripherals) and 11 → `bank_en[3]` (high RAM). No more than one `bank_en` bit is ever high.
- R3: `req_size` selects the number of byte cycles: 0 gives 1, 1 gives 2, and 2 or 3 give 4. The byte cycles run on consecutive clocks.
- R4: Byte n of an access uses the address base+n, computed modulo 2^16. `bus_addr` carries bits 11:0 of that address. An access that crosses a bank boundary moves its strobe to the new bank mid-sequence.
- R5: Data is little-endian. A store drives `req_wdata[8n+7:8n]` on `bus_wdata` in byte cycle n. A load returns the byte read in cycle n in `req_rdata[8n+7:8n]`, with all unused upper bytes zero.
- R6: `req_ack` is high for exactly one cycle, and no bank is strobed in that cycle. With N byte cycles and the request sampled at clock edge E0, a store is acknowledged in the cycle after edge E_N and a load in the cycle after edge E_(N+1).
- R7: Stores into the ROM bank are ignored. The byte cycle still takes place with `bank_en[1]` high, but `bus_we` stays low, so the ROM contents read back unchanged.
- R8: `req_valid` is sampled only in IDLE. A request, or a change of request fields, during a transfer or in its acknowledge cycle has no effect on that transfer and starts no new one.
- R9: A peripheral access at 0x8000+k strobes `bank_en[2]` with `bus_addr` = k. For example, 0x8009 gives index 0x009.
- R10: `bus_we` is high only during byte cycles of a store. During the byte cycles of a load it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request, sampled in IDLE |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| req_addr | input | 16 | Byte address of the lowest byte |
| req_wdata | input | 32 | Store data, least significant byte first |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Load data, valid with req_ack |
| bank_en | output | 4 | One-hot bank strobe for the current byte cycle |
| bus_addr | output | 12 | Index within the selected bank |
| bus_we | output | 1 | Write enable for the current byte cycle |
| bus_wdata | output | 8 | Write byte |
| ram_lo_rdata | input | 8 | Low RAM read byte (one cycle after strobe) |
| rom_rdata | input | 8 | ROM read byte |
| periph_rdata | input | 8 | Peripheral read byte |
| ram_hi_rdata | input | 8 | High RAM read byte |

## Verification
Two pairs of functions can land in the same cycle, and both are tested on purpose:
- Capture and strobe of different banks: in a load, the read byte of one cycle is taken in while the next byte is already being strobed. A 4-byte access at 0x3FFE puts these in the same cycle for different banks: the low RAM byte is captured while the ROM is strobed. Its result is judged against a bench-side shadow of every bank. A write-then-read at 0xFFFF covers the same case across the top wrap into the low RAM.
- Acknowledge and new request: a load is run with `req_valid` held high and its address fields changed, right through the acknowledge cycle. The bench then checks three things: the strobes still follow the original address, the acknowledge is a single pulse, and no new byte cycle starts afterwards.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_TAIL,
        ST_ACK
    } seq_state_t;

    localparam int unsigned NUM_BANKS = 4;
    localparam int unsigned ROM_BANK  = 1;

endpackage

// File: rtl/mbs_bank_decode.sv
module mbs_bank_decode #(
    parameter int unsigned NBANK  = 4,
    parameter int unsigned BANK_W = $clog2(NBANK)
) (
    input  logic              active,
    input  logic [BANK_W-1:0] bank_id,
    output logic [NBANK-1:0]  sel
);

    for (genvar g = 0; g < NBANK; g++) begin : g_sel
        assign sel[g] = active && (bank_id == BANK_W'(g));
    end

endmodule

// File: rtl/mbs_rd_mux.sv
module mbs_rd_mux #(
    parameter int unsigned NBANK  = 4,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned BANK_W = $clog2(NBANK)
) (
    input  logic [NBANK-1:0][BYTE_W-1:0] lanes,
    input  logic [BANK_W-1:0]            pick,
    output logic [BYTE_W-1:0]            byte_o
);

    assign byte_o = lanes[pick];

endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
    import mbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned IDX_W  = 12,
    parameter int unsigned NBANK  = 4,
    parameter int unsigned BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] req_rdata,
    output logic              xfer_active,
    output logic [BANK_W-1:0] cur_bank,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              bus_we,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] pend_bank,
    input  logic [BYTE_W-1:0] rd_byte
);

    localparam int unsigned NLANE  = DATA_W / BYTE_W;
    localparam int unsigned LANE_W = $clog2(NLANE);

    seq_state_t state_q, state_nx;

    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              write_q;
    logic [LANE_W-1:0] last_q;
    logic [LANE_W-1:0] idx_q;
    logic              pend_q;
    logic [LANE_W-1:0] pend_lane_q;
    logic [BANK_W-1:0] pend_bank_q;
    logic [ADDR_W-1:0] cur_addr;

    function automatic logic [LANE_W-1:0] last_lane(input logic [1:0] sz);
        case (sz)
            2'd0:    return '0;
            2'd1:    return LANE_W'(1);
            default: return LANE_W'(NLANE - 1);
        endcase
    endfunction

    assign cur_addr = base_q + ADDR_W'(idx_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_nx = ST_XFER;
            ST_XFER: if (idx_q == last_q) state_nx = write_q ? ST_ACK : ST_TAIL;
            ST_TAIL: state_nx = ST_ACK;
            ST_ACK:  state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            wdata_q     <= '0;
            rdata_q     <= '0;
            write_q     <= 1'b0;
            last_q      <= '0;
            idx_q       <= '0;
            pend_q      <= 1'b0;
            pend_lane_q <= '0;
            pend_bank_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                base_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
                last_q  <= last_lane(req_size);
                idx_q   <= '0;
                rdata_q <= '0;
            end else if (state_q == ST_XFER && idx_q != last_q) begin
                idx_q <= idx_q + LANE_W'(1);
            end
            pend_q      <= (state_q == ST_XFER) && !write_q;
            pend_lane_q <= idx_q;
            pend_bank_q <= cur_addr[ADDR_W-1 -: BANK_W];
            for (int l = 0; l < NLANE; l++) begin
                if (pend_q && pend_lane_q == LANE_W'(l))
                    rdata_q[l*BYTE_W +: BYTE_W] <= rd_byte;
            end
        end
    end

    // outputs
    always_comb begin
        xfer_active = (state_q == ST_XFER);
        cur_bank    = cur_addr[ADDR_W-1 -: BANK_W];
        cur_idx     = cur_addr[IDX_W-1:0];
        bus_we      = xfer_active && write_q && (cur_bank != BANK_W'(ROM_BANK));
        bus_wdata   = '0;
        for (int l = 0; l < NLANE; l++) begin
            if (idx_q == LANE_W'(l)) bus_wdata = wdata_q[l*BYTE_W +: BYTE_W];
        end
        req_ack     = (state_q == ST_ACK);
        req_rdata   = rdata_q;
        pend_bank   = pend_bank_q;
    end

    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && $past(state_q) == ST_XFER)
            |-> cur_addr == $past(cur_addr) + ADDR_W'(1));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(base_q) && $stable(write_q));

endmodule

// File: rtl/mem_byte_seq.sv
module mem_byte_seq
    import mbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned IDX_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] req_rdata,
    output logic [3:0]        bank_en,
    output logic [IDX_W-1:0]  bus_addr,
    output logic              bus_we,
    output logic [BYTE_W-1:0] bus_wdata,
    input  logic [BYTE_W-1:0] ram_lo_rdata,
    input  logic [BYTE_W-1:0] rom_rdata,
    input  logic [BYTE_W-1:0] periph_rdata,
    input  logic [BYTE_W-1:0] ram_hi_rdata
);

    localparam int unsigned NBANK  = NUM_BANKS;
    localparam int unsigned BANK_W = $clog2(NBANK);

    logic                        xfer_active;
    logic [BANK_W-1:0]           cur_bank;
    logic [BANK_W-1:0]           pend_bank;
    logic [BYTE_W-1:0]           rd_byte;
    logic [NBANK-1:0][BYTE_W-1:0] bank_rd;

    assign bank_rd = {ram_hi_rdata, periph_rdata, rom_rdata, ram_lo_rdata};

    mbs_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W),
        .IDX_W(IDX_W), .NBANK(NBANK), .BANK_W(BANK_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_rdata(req_rdata),
        .xfer_active(xfer_active), .cur_bank(cur_bank), .cur_idx(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata),
        .pend_bank(pend_bank), .rd_byte(rd_byte)
    );

    mbs_bank_decode #(.NBANK(NBANK), .BANK_W(BANK_W)) u_dec (
        .active(xfer_active), .bank_id(cur_bank), .sel(bank_en)
    );

    mbs_rd_mux #(.NBANK(NBANK), .BYTE_W(BYTE_W), .BANK_W(BANK_W)) u_mux (
        .lanes(bank_rd), .pick(pend_bank), .byte_o(rd_byte)
    );

    // R2
    bank_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_en));

    // R7
    rom_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_en[ROM_BANK] |-> !bus_we);

    // R10
    we_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bank_en != '0));

    // R6
    ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (bank_en == '0));

endmodule

// File: tb/mem_byte_seq_test.sv
`timescale 1ns/1ps
module mem_byte_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ack;
    logic [31:0] req_rdata;
    logic [3:0]  bank_en;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [7:0]  bus_wdata;
    logic [7:0]  srd [4];
    logic [7:0]  smem [4][256];
    logic [7:0]  shadow [4][256];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [11:0] first_idx;

    always #2 clk = ~clk;

    mem_byte_seq uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_rdata(req_rdata),
        .bank_en(bank_en), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .ram_lo_rdata(srd[0]), .rom_rdata(srd[1]),
        .periph_rdata(srd[2]), .ram_hi_rdata(srd[3])
    );

    function automatic logic [7:0] init_byte(input int b, input int i);
        return (b == 1) ? 8'((i * 7 + 3) & 255) : 8'h00;
    endfunction

    // synchronous bank models: data one cycle after strobe
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 4; b++)
                for (int i = 0; i < 256; i++) smem[b][i] <= init_byte(b, i);
        end else begin
            for (int b = 0; b < 4; b++) begin
                if (bank_en[b]) begin
                    if (bus_we) smem[b][bus_addr[7:0]] <= bus_wdata;
                    srd[b] <= smem[b][bus_addr[7:0]];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input logic wr, input logic [1:0] sz, input logic [15:0] addr,
                           input logic [31:0] wd, input bit hold);
        int n;
        int lat;
        int sc;
        bit got;
        logic [31:0] exp;
        logic [15:0] a;
        n   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        lat = wr ? n + 1 : n + 2;
        exp = '0;
        for (int k = 0; k < n; k++) begin
            a = addr + 16'(k);
            exp[8*k +: 8] = shadow[a[15:14]][a[7:0]];
            if (wr && a[15:14] != 2'd1) shadow[a[15:14]][a[7:0]] = wd[8*k +: 8];
        end
        sc  = 0;
        got = 1'b0;
        first_idx = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
        for (int cyc = 1; cyc <= 12; cyc++) begin
            @(negedge clk);
            if (cyc == 1) begin
                if (hold) begin
                    req_addr  = addr ^ 16'h4444;
                    req_write = ~wr;
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (bank_en != 4'b0) begin
                a = addr + 16'(sc);
                if (sc == 0) first_idx = bus_addr;
                chk(bank_en == (4'b1 << a[15:14]), "R2 bank strobe", 32'(bank_en), 32'(4'b1 << a[15:14]));
                chk(bus_addr == a[11:0], "R4 byte address", 32'(bus_addr), 32'(a[11:0]));
                chk(bus_we == (wr && a[15:14] != 2'd1), "R7 R10 write enable", 32'(bus_we),
                    32'(wr && a[15:14] != 2'd1));
                if (wr) chk(bus_wdata == wd[8*sc +: 8], "R5 write byte", 32'(bus_wdata), 32'(wd[8*sc +: 8]));
                sc++;
            end
            if (req_ack) begin
                got = 1'b1;
                chk(cyc == lat, "R6 ack latency", 32'(cyc), 32'(lat));
                if (!wr) chk(req_rdata == exp, "R5 read data", req_rdata, exp);
                break;
            end
        end
        chk(got, "R6 ack seen", 32'(got), 32'd1);
        chk(sc == n, "R3 byte cycle count", 32'(sc), 32'(n));
        req_valid = 1'b0;
        @(negedge clk);
        chk(!req_ack && bank_en == 4'b0, "R6 R8 single ack", {27'b0, req_ack, bank_en}, 32'd0);
        if (hold) begin
            @(negedge clk);
            chk(bank_en == 4'b0, "R8 no restart", 32'(bank_en), 32'd0);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [15:0] addr;
        logic [31:0] wd;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd2, 16'h0010, 32'hA1B2C3D4},
        '{1'b0, 2'd2, 16'h0010, 32'h0},
        '{1'b0, 2'd0, 16'h0012, 32'h0},
        '{1'b1, 2'd1, 16'hC020, 32'h0000BEEF},
        '{1'b0, 2'd1, 16'hC020, 32'h0},
        '{1'b0, 2'd2, 16'h4004, 32'h0},
        '{1'b1, 2'd2, 16'h4004, 32'hFFFFFFFF},
        '{1'b0, 2'd2, 16'h4004, 32'h0},
        '{1'b1, 2'd0, 16'h8009, 32'h0000003C},
        '{1'b0, 2'd0, 16'h8009, 32'h0},
        '{1'b1, 2'd2, 16'h3FFE, 32'h11223344},
        '{1'b0, 2'd2, 16'h3FFE, 32'h0},
        '{1'b0, 2'd3, 16'h0010, 32'h0},
        '{1'b1, 2'd1, 16'hFFFF, 32'h00005A69},
        '{1'b0, 2'd1, 16'hFFFF, 32'h0}
    };

    initial begin
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 256; i++) shadow[b][i] = init_byte(b, i);
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(bank_en == 4'b0 && !bus_we && !req_ack, "R1 reset outputs",
            {27'b0, req_ack, bank_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bank_en == 4'b0 && !bus_we && !req_ack, "R1 after reset",
            {27'b0, req_ack, bank_en}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            run_txn(VECS[v].wr, VECS[v].sz, VECS[v].addr, VECS[v].wd, 1'b0);
            if (VECS[v].addr[15:14] == 2'd2)
                chk(first_idx == VECS[v].addr[11:0], "R9 peripheral index",
                    32'(first_idx), 32'(VECS[v].addr[11:0]));
        end

        // R8: request held and altered through the whole transfer and ack cycle
        run_txn(1'b0, 2'd2, 16'h0010, 32'h0, 1'b1);
        // R7: ROM still reads its initial content after the ignored store
        run_txn(1'b0, 2'd1, 16'h4000, 32'h0, 1'b0);
        // R3: sizes 0 and 1 as stores into high RAM, read back as 4 bytes
        run_txn(1'b1, 2'd0, 16'hC100, 32'hFFFFFF77, 1'b0);
        run_txn(1'b1, 2'd1, 16'hC101, 32'hFFFF6655, 1'b0);
        run_txn(1'b0, 2'd2, 16'hC100, 32'h0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule